// File: doc/BRIEF.md
# Multi-CPU device interrupt router

The router gathers level-sensitive interrupt requests from up to 64 device sources into one shared raw request vector and fans them out to four CPUs. Each CPU owns a 64-bit enable mask. A CPU's hard-interrupt line is high whenever at least one source is both pending in the raw vector and enabled in that CPU's mask. Several CPUs can therefore enable the same source, and each sees it independently.

Software reaches the router through a 32-bit CSR port. Every 64-bit register is split into a low word at its base offset and a high word at base + 4. Software can read and write the four masks. It can also read the raw vector and, for each CPU, a masked view equal to that CPU's mask ANDed with the raw vector. A cascaded legacy interrupt controller has a dedicated input that is folded into source slot 55. Prioritising and vectoring the pending sources is left to the CPU side.

Top module: `irq_router`

## Requirements
- R1: Raw request bit n is registered from `src_i[n]` on every clock edge. Bit n is 1 in the cycle after a rising edge at which the source was high, and 0 in the cycle after an edge at which it was low.
- R2: Raw request bit 55 is registered from `src_i[55] | legacy_irq_i`, so a high level on the legacy cascade input sets bit 55 even while `src_i[55]` is low.
- R3: The masks of CPUs 0, 1, 2 and 3 are read/write at offsets 0x200, 0x240, 0x600 and 0x640. The low word holds bits 31:0 and base + 4 holds bits 63:32. A write takes effect at the clock edge of the request. Read data appears on `csr_rdata_o` in the cycle after the request.
- R4: The masked request registers of CPUs 0, 1, 2 and 3 are read-only at offsets 0x280, 0x2C0, 0x680 and 0x6C0, with the same word split as R3. Each reads as the CPU's mask AND the raw vector.
- R5: The raw vector is read-only at offset 0x300 (bits 31:0) and 0x304 (bits 63:32).
- R6: `cpu_irq_o[i]` is 1 exactly when mask i AND raw is nonzero. It follows any mask write or raw change in the same cycle as the register update.
- R7: A write to a masked request or raw register changes no state and does not raise `csr_err_o`.
- R8: An access to any other offset raises `csr_err_o` for one cycle, in the cycle after the request. This includes any offset with bits 1:0 nonzero and any offset of +8 or more within a register slot. Such a read returns 0xFFFFFFFF, and such a write changes no mask.
- R9: While `rst_ni` is low, all masks and the raw vector are 0, every `cpu_irq_o` bit is 0, `csr_err_o` is 0 and `csr_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Device interrupt levels, one per source |
| legacy_irq_i | input | 1 | Cascaded legacy controller interrupt, folded into source 55 |
| csr_req_i | input | 1 | CSR access request, one cycle per access |
| csr_we_i | input | 1 | 1 for write, 0 for read |
| csr_addr_i | input | 12 | CSR byte offset |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Read data, valid in the cycle after a read |
| csr_err_o | output | 1 | Error response for an unmapped access, in the cycle after it |
| cpu_irq_o | output | 4 | Hard-interrupt line per CPU |

## Verification
The assertions assume that a CSR request lasts one cycle and that the address and write data are stable while `csr_req_i` is high. They also assume that source levels change only between clock edges. The bench drives every input on the falling clock edge and issues each access as a single-cycle pulse, so it keeps within these assumptions. Random phases mix mask writes, reads of every register class, stray offsets and source toggles. A behavioural model predicts the CPU lines on every cycle and the read data after every access.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NCPU   = 4;
  localparam int CPU_W  = 2;
  localparam int WORD_W = 4;
  localparam int SLOT_W = 6;
  localparam logic [11:0] RAW_OFF = 12'h300;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_MASK,
    REG_MREQ,
    REG_RAW
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic [CPU_W-1:0]   cpu;
    logic [WORD_W-1:0]  word;
  } csr_sel_t;

  // CPUs 0/1 live in the low bank, 2/3 in the high bank.
  function automatic logic [11:0] mask_off(input int i);
    return (i < 2) ? 12'(12'h200 + i * 12'h40) : 12'(12'h600 + (i - 2) * 12'h40);
  endfunction

  function automatic logic [11:0] mreq_off(input int i);
    return 12'(mask_off(i) + 12'h080);
  endfunction
endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_router_pkg::*;
#(
  parameter int AW     = 12,
  parameter int HALVES = 2
) (
  input  logic [AW-1:0] addr_i,
  output csr_sel_t      sel_o
);
  logic [AW-1:0]     base;
  logic [WORD_W-1:0] word;
  logic              in_slot;

  assign base    = {addr_i[AW-1:SLOT_W], {SLOT_W{1'b0}}};
  assign word    = addr_i[SLOT_W-1:2];
  assign in_slot = (addr_i[1:0] == 2'b00) && (int'(word) < HALVES);

  always_comb begin
    sel_o      = '0;
    sel_o.kind = REG_NONE;
    sel_o.word = word;
    for (int i = 0; i < NCPU; i++) begin
      if (base == AW'(mask_off(i))) begin
        sel_o.kind = REG_MASK;
        sel_o.cpu  = CPU_W'(i);
      end
      if (base == AW'(mreq_off(i))) begin
        sel_o.kind = REG_MREQ;
        sel_o.cpu  = CPU_W'(i);
      end
    end
    if (base == AW'(RAW_OFF)) sel_o.kind = REG_RAW;
    if (!in_slot) sel_o.kind = REG_NONE;
  end
endmodule

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
  parameter int NSRC       = 64,
  parameter int LEGACY_SRC = 55
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            legacy_i,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] raw_d;
  logic            live_q;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    if (n == LEGACY_SRC) begin : g_cascade
      assign raw_d[n] = src_i[n] | legacy_i;
    end else begin : g_plain
      assign raw_d[n] = src_i[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o  <= '0;
      live_q <= 1'b0;
    end else begin
      raw_o  <= raw_d;
      live_q <= 1'b1;
    end
  end

  // R2
  legacy_sets_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(legacy_i) |-> raw_o[LEGACY_SRC]);

  // R1
  low_src_clears_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(src_i[0]) == 1'b0 |-> raw_o[0] == 1'b0);
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_router_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int DW   = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [CPU_W-1:0]               wr_cpu_i,
  input  logic [WORD_W-1:0]              wr_word_i,
  input  logic [DW-1:0]                  wdata_i,
  output logic [NCPU-1:0][NSRC-1:0]      mask_o
);
  localparam int HALVES = NSRC / DW;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar w = 0; w < HALVES; w++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mask_o[c][w*DW +: DW] <= '0;
        end else if (wr_i && wr_cpu_i == CPU_W'(c) && wr_word_i == WORD_W'(w)) begin
          mask_o[c][w*DW +: DW] <= wdata_i;
        end
      end
    end
  end

  // R3
  idle_mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NSRC       = 64,
  parameter int DW         = 32,
  parameter int AW         = 12,
  parameter int LEGACY_SRC = 55
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            legacy_irq_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [DW-1:0]   csr_wdata_i,
  output logic [DW-1:0]   csr_rdata_o,
  output logic            csr_err_o,
  output logic [NCPU-1:0] cpu_irq_o
);
  localparam int HALVES = NSRC / DW;

  csr_sel_t                  sel;
  logic [NSRC-1:0]           raw;
  logic [NCPU-1:0][NSRC-1:0] mask;
  logic [NSRC-1:0]           rd_val;
  logic [DW-1:0]             rd_word;
  logic                      bad;

  irq_csr_decode #(.AW(AW), .HALVES(HALVES)) u_decode (
    .addr_i (csr_addr_i),
    .sel_o  (sel)
  );

  irq_raw_capture #(.NSRC(NSRC), .LEGACY_SRC(LEGACY_SRC)) u_raw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .legacy_i (legacy_irq_i),
    .raw_o    (raw)
  );

  irq_mask_bank #(.NSRC(NSRC), .DW(DW)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (csr_req_i && csr_we_i && sel.kind == REG_MASK),
    .wr_cpu_i  (sel.cpu),
    .wr_word_i (sel.word),
    .wdata_i   (csr_wdata_i),
    .mask_o    (mask)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_irq
    assign cpu_irq_o[c] = |(mask[c] & raw);
  end

  always_comb begin
    unique case (sel.kind)
      REG_MASK: rd_val = mask[sel.cpu];
      REG_MREQ: rd_val = mask[sel.cpu] & raw;
      REG_RAW:  rd_val = raw;
      default:  rd_val = '0;
    endcase
  end

  assign rd_word = DW'(rd_val >> (int'(sel.word) * DW));
  assign bad     = (sel.kind == REG_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_rdata_o <= '0;
      csr_err_o   <= 1'b0;
    end else begin
      csr_err_o <= csr_req_i && bad;
      if (csr_req_i && !csr_we_i) csr_rdata_o <= bad ? '1 : rd_word;
    end
  end

  // R6
  no_raw_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw == '0 |-> cpu_irq_o == '0);

  // R8
  bad_read_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && !csr_we_i && bad |=> csr_err_o && csr_rdata_o == '1);

  // R8
  bad_write_keeps_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_we_i && bad |=> $stable(mask));

  // R7
  ro_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_we_i && (sel.kind == REG_MREQ || sel.kind == REG_RAW)
    |=> $stable(mask) && !csr_err_o);
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        legacy = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  irq;

  int    checks = 0;
  int    fails = 0;
  string cur_tag = "R3";

  irq_router u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .src_i        (src),
    .legacy_irq_i (legacy),
    .csr_req_i    (req),
    .csr_we_i     (we),
    .csr_addr_i   (addr),
    .csr_wdata_i  (wdata),
    .csr_rdata_o  (rdata),
    .csr_err_o    (err),
    .cpu_irq_o    (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;
  logic        exp_rd_v, exp_err;
  logic [31:0] exp_rdata;
  string       exp_tag = "R9";

  function automatic void bdecode(input logic [11:0] a, output int kind,
                                  output int cpu, output int word);
    logic [11:0] base;
    base = a & 12'hFC0;
    word = int'((a & 12'h03F) >> 2);
    kind = 0;
    cpu  = 0;
    case (base)
      12'h200: begin kind = 1; cpu = 0; end
      12'h240: begin kind = 1; cpu = 1; end
      12'h600: begin kind = 1; cpu = 2; end
      12'h640: begin kind = 1; cpu = 3; end
      12'h280: begin kind = 2; cpu = 0; end
      12'h2C0: begin kind = 2; cpu = 1; end
      12'h680: begin kind = 2; cpu = 2; end
      12'h6C0: begin kind = 2; cpu = 3; end
      12'h300: kind = 3;
      default: kind = 0;
    endcase
    if (a[1:0] != 2'b00 || word > 1) kind = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_mask[i] = '0;
      m_raw     = '0;
      exp_rd_v  = 1'b0;
      exp_err   = 1'b0;
      exp_rdata = '0;
    end else begin
      exp_rd_v = 1'b0;
      exp_err  = 1'b0;
      if (req) begin
        int k, c, w;
        logic [63:0] v;
        bdecode(addr, k, c, w);
        exp_tag = cur_tag;
        v = (k == 1) ? m_mask[c] : (k == 2) ? (m_mask[c] & m_raw) : m_raw;
        if (k == 0) begin
          exp_err = 1'b1;
          if (!we) begin exp_rd_v = 1'b1; exp_rdata = '1; end
        end else if (!we) begin
          exp_rd_v  = 1'b1;
          exp_rdata = w[0] ? v[63:32] : v[31:0];
        end else if (k == 1) begin
          if (w[0]) m_mask[c][63:32] = wdata; else m_mask[c][31:0] = wdata;
        end
      end
      m_raw = src;
      m_raw[55] = src[55] | legacy;
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] e;
      for (int i = 0; i < 4; i++) e[i] = |(m_mask[i] & m_raw);
      check("R6", "cpu_irq", 64'(irq), 64'(e));
      check(exp_err ? "R8" : exp_tag, "csr_err", 64'(err), 64'(exp_err));
      if (exp_rd_v) check(exp_tag, "csr_rdata", 64'(rdata), 64'(exp_rdata));
    end
  end

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; cur_tag = tag;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic drive_src(input logic [63:0] v, input logic l);
    @(negedge clk);
    src = v; legacy = l;
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    // R9 reset state
    check("R9", "reset irq", 64'(irq), 64'h0);
    check("R9", "reset err", 64'(err), 64'h0);
    check("R9", "reset rdata", 64'(rdata), 64'h0);
    @(negedge clk) rst_n = 1'b1;
    access(0, 12'h200, 0, "R9");
    access(0, 12'h644, 0, "R9");

    // R1 raw sampling, several patterns
    drive_src(64'hA5A5_0000_0F0F_1234, 1'b0);
    access(0, 12'h300, 0, "R1");
    access(0, 12'h304, 0, "R1");
    drive_src(64'h0000_0000_0000_0000, 1'b0);
    access(0, 12'h300, 0, "R1");
    access(0, 12'h304, 0, "R5");

    // R2 legacy cascade into bit 55
    drive_src(64'h0000_0001_0000_0000, 1'b1);
    access(0, 12'h304, 0, "R2");
    drive_src(64'h0080_0000_0000_0000, 1'b0);
    access(0, 12'h304, 0, "R2");

    // R3 mask programming and readback
    access(1, 12'h200, 32'h0000_00FF, "R3");
    access(1, 12'h244, 32'h0080_0000, "R3");
    access(1, 12'h600, 32'hFFFF_0000, "R3");
    access(1, 12'h644, 32'h0000_0001, "R3");
    access(0, 12'h200, 0, "R3");
    access(0, 12'h244, 0, "R3");
    access(0, 12'h600, 0, "R3");
    access(0, 12'h644, 0, "R3");

    // R4/R6 masked views under distinct source patterns
    drive_src(64'h0000_0001_8000_0001, 1'b0);
    access(0, 12'h280, 0, "R4");
    access(0, 12'h684, 0, "R4");
    access(0, 12'h680, 0, "R4");
    drive_src(64'h0000_0000_0000_0000, 1'b1);
    access(0, 12'h2C4, 0, "R4");
    access(0, 12'h6C4, 0, "R4");
    drive_src('0, 1'b0);
    repeat (2) @(negedge clk);

    // R7 writes to read-only registers
    drive_src(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    access(1, 12'h280, 32'hFFFF_FFFF, "R7");
    access(1, 12'h300, 32'h0, "R7");
    access(1, 12'h6C4, 32'h1234_5678, "R7");
    access(0, 12'h200, 0, "R7");
    access(0, 12'h300, 0, "R7");

    // R8 unmapped, slot overflow and misaligned
    access(0, 12'h000, 0, "R8");
    access(0, 12'h208, 0, "R8");
    access(0, 12'h201, 0, "R8");
    access(1, 12'h100, 32'hDEAD_BEEF, "R8");
    access(1, 12'h20C, 32'hDEAD_BEEF, "R8");
    access(0, 12'h200, 0, "R8");
    access(0, 12'h204, 0, "R8");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [11:0] a;
      sel = int'($urandom_range(0, 9));
      a = 12'($urandom_range(0, 4095));
      case (sel)
        0, 1: drive_src({$urandom, $urandom}, 1'($urandom));
        2, 3: access(1, 12'(bit'($urandom) ? 12'h200 : 12'h600) | 12'($urandom_range(0, 1) * 12'h40)
                         | 12'($urandom_range(0, 1) * 4), $urandom, "R3");
        4:    access(0, 12'h200 | 12'($urandom_range(0, 3) * 12'h40), 0, "R4");
        5:    access(0, 12'h680 | 12'($urandom_range(0, 1) * 12'h40) | 12'($urandom_range(0, 1) * 4), 0, "R4");
        6:    access(0, 12'h300 | 12'($urandom_range(0, 1) * 4), 0, "R5");
        7:    access(bit'($urandom), a, $urandom, "R8");
        default: @(negedge clk);
      endcase
    end

    // R9 reset mid-run clears masks
    access(1, 12'h240, 32'hFFFF_FFFF, "R3");
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R9", "reset irq mid-run", 64'(irq), 64'h0);
    @(negedge clk) rst_n = 1'b1;
    access(0, 12'h240, 0, "R9");
    drive_src(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    repeat (3) @(negedge clk);
    check("R9", "irq low with cleared masks", 64'(irq), 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule